// File: doc/BRIEF.md
# Burst Configuration Load Interface

This block loads configuration storage from a single 16-bit input port, one word per clock. Each transaction starts with an address word. The register class that this address falls in decides how many data words follow.

For most classes the data words are gathered in a staging buffer. The target is written in one commit once the final word has arrived, so it never sees a partly written burst. The gamma look-up table is the exception: it is filled one entry per accepted word through a separate write port, with an index that counts up by itself.

A hold input freezes the loader. While it is high the input word is ignored, and loading continues from the same point once it drops.

Top module: `cfg_burst_loader`

Address classes, keyed on the address word:
- address bits 15:4 equal 000h: coefficient set, ten words.
- 0200h to 020Fh: configuration register, one word.
- upper byte 09h or 0Bh: output or input bias register, one word.
- upper byte 0Ch: range-shift-limit register, four words.
- upper byte 0Dh: blanking flag count, two words.
- upper byte 0Eh: gamma table, `LUT_DEPTH` words.
- anything else: unknown.

## Requirements
- R1: After reset, and in the cycle after the last data word of any burst, the next accepted word is taken as an address. `wr_en_o` and `lut_we_o` are never high in the same cycle.
- R2: A coefficient address (bits 15:4 equal to 000h) takes ten data words. It produces exactly one commit, one cycle after the tenth word is accepted, with data word k on `wr_data_o[16k+15:16k]`.
- R3: A range-shift-limit address (upper byte 0Ch) takes four data words. It commits them in `wr_data_o[63:0]` in arrival order, with every higher bit zero.
- R4: A blanking flag count address (upper byte 0Dh) takes two data words. The commit carries the first word in bits 15:0 and bits 3:0 of the second word in bits 19:16, with every higher bit zero.
- R5: A configuration address (0200h to 020Fh) or a bias address (upper byte 09h or 0Bh) takes one data word. That word is committed in `wr_data_o[15:0]`, with every higher bit zero.
- R6: A gamma table address (upper byte 0Eh) takes `LUT_DEPTH` data words. Each one appears on `lut_data_o` with `lut_we_o` high, one cycle after it is accepted. `lut_idx_o` counts 0, 1, 2 and so on, and `wr_en_o` is never raised for this class.
- R7: While `hold_i` is high the input word is ignored. The burst position does not change, and no write appears in the following cycle. When `hold_i` returns low, loading resumes at the same word.
- R8: An address in no listed class consumes exactly one following data word and causes no write on either port.
- R9: A commit is a single-cycle pulse of `wr_en_o` that presents the burst's address on `wr_addr_o`. Two back-to-back one-word transactions give two separate pulses.
- R10: Reset clears `wr_en_o`, `lut_we_o` and `wr_data_o` and abandons any partial burst. The first word after reset is treated as an address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Stall: when high, the input word is ignored |
| word_i | input | WORD_W | Address or data word |
| wr_en_o | output | 1 | Commit strobe toward register storage |
| wr_addr_o | output | WORD_W | Address of the committed burst |
| wr_data_o | output | WORD_W*COEF_WORDS | Assembled burst data |
| lut_we_o | output | 1 | Gamma table entry write strobe |
| lut_idx_o | output | $clog2(LUT_DEPTH) | Gamma table entry index |
| lut_data_o | output | WORD_W | Gamma table entry data |

## Verification
The bench builds the loader with `LUT_DEPTH` set to 32 and every other parameter at its default. This keeps the full ten-word coefficient staging and the 20-bit flag packing, while a complete gamma burst, including the wrap of its index counter, fits into the random mix many times over. With the shorter table, a long run of random transactions with random hold gaps can be checked in a few thousand cycles. Directed cases cover back-to-back one-word transactions, unknown addresses and a reset in the middle of a burst.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  typedef enum logic [2:0] {
    CLS_COEF,
    CLS_CFG,
    CLS_BIAS,
    CLS_RSL,
    CLS_FLAG,
    CLS_LUT,
    CLS_NONE
  } cls_e;

  // classes whose burst ends in one staged commit
  function automatic logic cls_commits(cls_e c);
    return (c == CLS_COEF) || (c == CLS_CFG) || (c == CLS_BIAS) ||
           (c == CLS_RSL)  || (c == CLS_FLAG);
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0]  addr_i,
  output cfg_load_pkg::cls_e cls_o
);
  import cfg_load_pkg::*;

  logic [7:0]        hi_byte;
  logic [WORD_W-5:0] hi_bits;

  assign hi_byte = addr_i[WORD_W-1 -: 8];
  assign hi_bits = addr_i[WORD_W-1:4];

  always_comb begin
    cls_o = CLS_NONE;
    if (hi_bits == '0)                      cls_o = CLS_COEF;
    else if (hi_bits == (WORD_W-4)'('h020)) cls_o = CLS_CFG;
    else begin
      case (hi_byte)
        8'h09, 8'h0B: cls_o = CLS_BIAS;
        8'h0C:        cls_o = CLS_RSL;
        8'h0D:        cls_o = CLS_FLAG;
        8'h0E:        cls_o = CLS_LUT;
        default:      cls_o = CLS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_burst_seq.sv
module cfg_burst_seq #(
  parameter int WORD_W     = 16,
  parameter int COEF_WORDS = 10,
  parameter int RSL_WORDS  = 4,
  parameter int LUT_DEPTH  = 1024,
  parameter int CNT_W      = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic [WORD_W-1:0]  word_i,
  input  cfg_load_pkg::cls_e cls_dec_i,
  output logic               acc_addr_o,
  output logic               acc_data_o,
  output logic               last_o,
  output cfg_load_pkg::cls_e cls_o,
  output logic [WORD_W-1:0]  addr_o,
  output logic [CNT_W-1:0]   cnt_o
);
  import cfg_load_pkg::*;

  logic              in_data_q, in_data_n;
  cls_e              cls_q;
  logic [WORD_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n, len_m1;
  logic              cnt_en;

  always_comb begin
    case (cls_q)
      CLS_COEF: len_m1 = CNT_W'(COEF_WORDS - 1);
      CLS_RSL:  len_m1 = CNT_W'(RSL_WORDS - 1);
      CLS_FLAG: len_m1 = CNT_W'(1);
      CLS_LUT:  len_m1 = CNT_W'(LUT_DEPTH - 1);
      default:  len_m1 = '0;
    endcase
  end

  assign acc_addr_o = take_i & ~in_data_q;
  assign acc_data_o = take_i &  in_data_q;
  assign last_o     = acc_data_o & (cnt_q == len_m1);
  assign cnt_en     = acc_addr_o | acc_data_o;

  always_comb begin
    in_data_n = in_data_q;
    if (acc_addr_o)  in_data_n = 1'b1;
    else if (last_o) in_data_n = 1'b0;
    cnt_n = acc_addr_o ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data_q <= 1'b0;
      cls_q     <= CLS_NONE;
      addr_q    <= '0;
      cnt_q     <= '0;
    end else begin
      if (take_i)     in_data_q <= in_data_n;
      if (cnt_en)     cnt_q     <= cnt_n;
      if (acc_addr_o) begin
        cls_q  <= cls_dec_i;
        addr_q <= word_i;
      end
    end
  end

  assign cls_o  = cls_q;
  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/cfg_stage_commit.sv
module cfg_stage_commit #(
  parameter int WORD_W     = 16,
  parameter int COEF_WORDS = 10,
  parameter int LUT_DEPTH  = 1024,
  parameter int FLAG_W     = 20,
  parameter int CNT_W      = 10,
  localparam int DATA_W    = WORD_W * COEF_WORDS,
  localparam int LUT_AW    = $clog2(LUT_DEPTH),
  localparam int FLAG_HI   = FLAG_W - WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               acc_data_i,
  input  logic               last_i,
  input  cfg_load_pkg::cls_e cls_i,
  input  logic [WORD_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic               wr_en_o,
  output logic [WORD_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               lut_we_o,
  output logic [LUT_AW-1:0]  lut_idx_o,
  output logic [WORD_W-1:0]  lut_data_o
);
  import cfg_load_pkg::*;

  logic [WORD_W-1:0] stg_q [COEF_WORDS];
  logic [WORD_W-1:0] stg_n [COEF_WORDS];
  logic              stg_wr, commit, lut_wr;
  logic [DATA_W-1:0] data_n;

  assign stg_wr = acc_data_i && (cls_i != CLS_LUT) && (cnt_i < CNT_W'(COEF_WORDS));
  assign commit = acc_data_i && last_i && cls_commits(cls_i);
  assign lut_wr = acc_data_i && (cls_i == CLS_LUT);

  for (genvar g = 0; g < COEF_WORDS; g++) begin : g_stage
    logic hit;
    assign hit = stg_wr && (cnt_i == CNT_W'(g));
    always_comb begin
      if (clr_i)    stg_n[g] = '0;
      else if (hit) stg_n[g] = word_i;
      else          stg_n[g] = stg_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            stg_q[g] <= '0;
      else if (clr_i || hit) stg_q[g] <= stg_n[g];
    end
  end

  // assembly of the commit word includes the word accepted this cycle
  always_comb begin
    data_n = '0;
    if (cls_i == CLS_FLAG) begin
      data_n[WORD_W-1:0]       = stg_n[0];
      data_n[WORD_W +: FLAG_HI] = stg_n[1][FLAG_HI-1:0];
    end else begin
      for (int k = 0; k < COEF_WORDS; k++) data_n[k*WORD_W +: WORD_W] = stg_n[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      lut_we_o   <= 1'b0;
      lut_idx_o  <= '0;
      lut_data_o <= '0;
    end else begin
      wr_en_o  <= commit;
      lut_we_o <= lut_wr;
      if (commit) begin
        wr_addr_o <= addr_i;
        wr_data_o <= data_n;
      end
      if (lut_wr) begin
        lut_idx_o  <= cnt_i[LUT_AW-1:0];
        lut_data_o <= word_i;
      end
    end
  end
endmodule

// File: rtl/cfg_burst_loader.sv
module cfg_burst_loader #(
  parameter int WORD_W     = 16,
  parameter int COEF_WORDS = 10,
  parameter int RSL_WORDS  = 4,
  parameter int LUT_DEPTH  = 1024,
  parameter int FLAG_W     = 20,
  localparam int DATA_W    = WORD_W * COEF_WORDS,
  localparam int LUT_AW    = $clog2(LUT_DEPTH),
  localparam int STG_CW    = $clog2(COEF_WORDS),
  localparam int CNT_W     = (LUT_AW > STG_CW) ? LUT_AW : STG_CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              lut_we_o,
  output logic [LUT_AW-1:0] lut_idx_o,
  output logic [WORD_W-1:0] lut_data_o
);
  import cfg_load_pkg::*;

  cls_e              cls_dec, cls_cur;
  logic              acc_addr, acc_data, last_word;
  logic [WORD_W-1:0] addr_cur;
  logic [CNT_W-1:0]  cnt_cur;

  cfg_addr_decode #(.WORD_W(WORD_W)) u_dec (
    .addr_i (word_i),
    .cls_o  (cls_dec)
  );

  cfg_burst_seq #(
    .WORD_W(WORD_W), .COEF_WORDS(COEF_WORDS), .RSL_WORDS(RSL_WORDS),
    .LUT_DEPTH(LUT_DEPTH), .CNT_W(CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (~hold_i),
    .word_i     (word_i),
    .cls_dec_i  (cls_dec),
    .acc_addr_o (acc_addr),
    .acc_data_o (acc_data),
    .last_o     (last_word),
    .cls_o      (cls_cur),
    .addr_o     (addr_cur),
    .cnt_o      (cnt_cur)
  );

  cfg_stage_commit #(
    .WORD_W(WORD_W), .COEF_WORDS(COEF_WORDS), .LUT_DEPTH(LUT_DEPTH),
    .FLAG_W(FLAG_W), .CNT_W(CNT_W)
  ) u_stg (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (acc_addr),
    .acc_data_i (acc_data),
    .last_i     (last_word),
    .cls_i      (cls_cur),
    .addr_i     (addr_cur),
    .cnt_i      (cnt_cur),
    .word_i     (word_i),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .lut_we_o   (lut_we_o),
    .lut_idx_o  (lut_idx_o),
    .lut_data_o (lut_data_o)
  );
endmodule

// File: rtl/cfg_burst_loader_chk.sv
module cfg_burst_loader_chk #(
  parameter int WORD_W     = 16,
  parameter int COEF_WORDS = 10,
  parameter int RSL_WORDS  = 4,
  parameter int LUT_DEPTH  = 1024,
  parameter int FLAG_W     = 20,
  localparam int DATA_W    = WORD_W * COEF_WORDS,
  localparam int LUT_AW    = $clog2(LUT_DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_i,
  input logic              wr_en_o,
  input logic [WORD_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              lut_we_o,
  input logic [LUT_AW-1:0] lut_idx_o
);
  import cfg_load_pkg::*;

  logic [LUT_AW-1:0] exp_idx;
  cls_e              wr_cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        exp_idx <= '0;
    else if (lut_we_o) exp_idx <= (exp_idx == LUT_AW'(LUT_DEPTH - 1)) ? '0 : exp_idx + LUT_AW'(1);
  end

  cfg_addr_decode #(.WORD_W(WORD_W)) u_chk_dec (.addr_i(wr_addr_o), .cls_o(wr_cls));

  // R1
  a_r1_ports_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_o && lut_we_o));

  // R3
  a_r3_rsl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_cls == CLS_RSL) |-> (wr_data_o[DATA_W-1:RSL_WORDS*WORD_W] == '0));

  // R4
  a_r4_flag_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_cls == CLS_FLAG) |-> (wr_data_o[DATA_W-1:FLAG_W] == '0));

  // R6
  a_r6_lut_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    lut_we_o |-> (lut_idx_o == exp_idx));

  // R7
  a_r7_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (!wr_en_o && !lut_we_o));

  // R8
  a_r8_commit_known_class: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> cls_commits(wr_cls));

  // R9
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);
endmodule

bind cfg_burst_loader cfg_burst_loader_chk #(
  .WORD_W(WORD_W), .COEF_WORDS(COEF_WORDS), .RSL_WORDS(RSL_WORDS),
  .LUT_DEPTH(LUT_DEPTH), .FLAG_W(FLAG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hold_i    (hold_i),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o),
  .lut_we_o  (lut_we_o),
  .lut_idx_o (lut_idx_o)
);

// File: tb/cfg_burst_loader_bench.sv
`timescale 1ns/1ps
module cfg_burst_loader_bench;
  localparam int LUTD = 32;
  localparam int DW   = 160;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold_i = 1'b1;
  logic [15:0]   word_i = '0;
  logic          wr_en_o, lut_we_o;
  logic [15:0]   wr_addr_o, lut_data_o;
  logic [DW-1:0] wr_data_o;
  logic [4:0]    lut_idx_o;

  int checks = 0, errors = 0;
  int n_commit = 0, n_lut = 0, lut_bad = 0, n_dbl = 0;
  logic          prev_wr = 1'b0;
  logic [15:0]   cm_addr;
  logic [DW-1:0] cm_data;
  logic [15:0]   wbuf [0:LUTD-1];

  always #10 clk = ~clk;

  cfg_burst_loader #(.LUT_DEPTH(LUTD)) u_cfg_burst_loader (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .word_i(word_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .lut_we_o(lut_we_o), .lut_idx_o(lut_idx_o), .lut_data_o(lut_data_o)
  );

  // monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en_o) begin
        n_commit++;
        cm_addr = wr_addr_o;
        cm_data = wr_data_o;
        if (prev_wr) n_dbl++;
      end
      prev_wr = wr_en_o;
      if (lut_we_o) begin
        n_lut++;
        if (lut_data_o !== wbuf[lut_idx_o]) lut_bad++;
      end
    end else prev_wr = 1'b0;
  end

  task automatic check(input logic ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [15:0] a);
    if (a[15:4] == 12'h000)                 return 10;
    if (a[15:4] == 12'h020)                 return 1;
    if (a[15:8] == 8'h09 || a[15:8] == 8'h0B) return 1;
    if (a[15:8] == 8'h0C)                   return 4;
    if (a[15:8] == 8'h0D)                   return 2;
    if (a[15:8] == 8'h0E)                   return LUTD;
    return 1;
  endfunction

  function automatic int exp_kind(input logic [15:0] a); // 0 commit, 1 table, 2 none
    if (a[15:8] == 8'h0E) return 1;
    if (a[15:4] == 12'h000 || a[15:4] == 12'h020 || a[15:8] == 8'h09 ||
        a[15:8] == 8'h0B || a[15:8] == 8'h0C || a[15:8] == 8'h0D) return 0;
    return 2;
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    if (a[15:4] == 12'h000) return "R2";
    if (a[15:8] == 8'h0C)   return "R3";
    if (a[15:8] == 8'h0D)   return "R4";
    if (a[15:8] == 8'h0E)   return "R6";
    if (exp_kind(a) == 2)   return "R8";
    return "R5";
  endfunction

  function automatic logic [DW-1:0] exp_data(input logic [15:0] a, input int n);
    logic [DW-1:0] d = '0;
    if (a[15:8] == 8'h0D) begin
      d[15:0]  = wbuf[0];
      d[19:16] = wbuf[1][3:0];
    end else begin
      for (int k = 0; k < n; k++) d[k*16 +: 16] = wbuf[k];
    end
    return d;
  endfunction

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    hold_i = 1'b0;
    word_i = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hold_i = 1'b1;
      word_i = 16'($urandom);
    end
  endtask

  task automatic run_txn(input logic [15:0] a, input int pause_pct);
    int n, c0, l0, b0;
    n = exp_len(a);
    c0 = n_commit; l0 = n_lut; b0 = lut_bad;
    send(a);
    for (int i = 0; i < n; i++) begin
      if (int'($urandom % 100) < pause_pct) idle(1 + int'($urandom % 3));
      send(wbuf[i]);
    end
    idle(3);
    case (exp_kind(a))
      0: begin
        check(n_commit - c0 == 1, tag_of(a), DW'(n_commit - c0), DW'(1));
        check(cm_addr == a, tag_of(a), DW'(cm_addr), DW'(a));
        check(cm_data == exp_data(a, n), tag_of(a), cm_data, exp_data(a, n));
      end
      1: begin
        check(n_lut - l0 == n, "R6", DW'(n_lut - l0), DW'(n));
        check(lut_bad == b0, "R6", DW'(lut_bad - b0), DW'(0));
        check(n_commit == c0, "R6", DW'(n_commit - c0), DW'(0));
      end
      default: begin
        check(n_commit == c0 && n_lut == l0, "R8", DW'(n_commit - c0), DW'(0));
      end
    endcase
  endtask

  function automatic logic [15:0] rand_addr();
    logic [15:0] r = 16'($urandom);
    case ($urandom % 8)
      0: return {12'h000, r[3:0]};
      1: return {12'h020, r[3:0]};
      2: return {8'h09, r[7:0]};
      3: return {8'h0B, r[7:0]};
      4: return {8'h0C, r[7:0]};
      5: return {8'h0D, r[7:0]};
      6: return {8'h0E, r[7:0]};
      default: return {4'h7, r[11:0]};
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0, d0;
    void'($urandom(32'd4242));
    for (int i = 0; i < LUTD; i++) wbuf[i] = '0;
    idle(3);
    // R10 reset state
    check(!wr_en_o && !lut_we_o && wr_data_o == '0, "R10", DW'({wr_en_o, lut_we_o}), DW'(0));
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2 + R7: coefficient set 2, values 0..9, with hold gaps
    for (int i = 0; i < 10; i++) wbuf[i] = 16'(i);
    run_txn(16'h0002, 60);

    // R5 directed bias and configuration values
    wbuf[0] = 16'h007F; run_txn(16'h0B01, 0);
    wbuf[0] = 16'h0010; run_txn(16'h0903, 0);
    wbuf[0] = 16'h1A5C; run_txn(16'h0201, 0);

    // R4 flag count B3C27h, upper bits of second word must be dropped
    wbuf[0] = 16'h3C27; wbuf[1] = 16'hFFFB; run_txn(16'h0D00, 30);

    // R3 shift-limit register
    for (int i = 0; i < 4; i++) wbuf[i] = 16'hA000 + 16'(i);
    run_txn(16'h0C05, 0);

    // R6 full table burst with hold gaps
    for (int i = 0; i < LUTD; i++) wbuf[i] = 16'($urandom);
    run_txn(16'h0E00, 20);

    // R8 unknown address, then a normal one must follow
    wbuf[0] = 16'h0902; run_txn(16'h7123, 0);
    wbuf[0] = 16'h4444; run_txn(16'h0B7E, 0);

    // R1 + R9 back-to-back single-word transactions, no idle between
    c0 = n_commit; d0 = n_dbl;
    send(16'h0901); send(16'h1111); send(16'h0B02); send(16'h2222);
    idle(3);
    check(n_commit - c0 == 2, "R9", DW'(n_commit - c0), DW'(2));
    check(n_dbl == d0, "R9", DW'(n_dbl - d0), DW'(0));
    check(cm_addr == 16'h0B02 && cm_data == DW'(16'h2222), "R1", DW'(cm_addr), DW'(16'h0B02));

    // R10 reset in the middle of a coefficient burst
    send(16'h0004); send(16'h0AAA); send(16'h0BBB);
    @(negedge clk); rst_n = 1'b0; hold_i = 1'b1;
    idle(2);
    check(!wr_en_o && wr_data_o == '0, "R10", wr_data_o, '0);
    @(negedge clk); rst_n = 1'b1;
    wbuf[0] = 16'h00C3; run_txn(16'h0903, 0);

    // random mix with holds
    for (int t = 0; t < 60; t++) begin
      logic [15:0] a;
      a = rand_addr();
      for (int i = 0; i < LUTD; i++) wbuf[i] = 16'($urandom);
      run_txn(a, int'($urandom % 40));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule